// File: doc/BRIEF.md
# Two-Stage Peripheral Clock Generator

This block makes one peripheral's functional clock from a set of shared input clocks. Two mux-and-divide stages sit in a row. Each stage picks one input with a 3-bit code and counts that input's pulses down by a programmable ratio from 1 to 256. Each stage can also flip the polarity of its level output. The second stage can take the first stage's terminal-count pulse as its input, so the two ratios multiply. A control word enables the generated output. It also gates the bus-interface tick and the peripheral-interface tick that pass through the block.

All clocks are modelled as single-cycle enable pulses in one reference clock domain. An input "clock" is a pulse on its input pin. A stage output has two forms: a level, whose high phase spans part of the divided period, and a tick, which is one pulse per divided period. Software programs the block through a word-addressed register port. Writes take one clock. Reads are combinational from the current register contents.

The block carries no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal that is sampled on every clock.

Top module: `twostage_clkgen`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero. The level outputs, the tick output and both gated ticks are low.
- R2: The control word is at word address 0, with bits 3:0 implemented. The first stage's generator word is at address 1 and the second stage's is at address 3. In a generator word, bit 1 is invert, bits 4:2 are the source code and bits 12:5 are the ratio minus one. Addresses 2 and 4 are reserved and ignore writes. Reserved addresses, address 5 and above, and unimplemented bits all read zero.
- R3: A running stage with ratio field D emits exactly one tick for every D+1 pulses of its selected input. The tick comes in the same cycle as the last of those pulses.
- R4: Within each divided period, a running stage's level is high for the first ceil((D+1)/2) input pulses and low for the rest. The first part is one pulse longer when the ratio is odd.
- R5: Source codes 0 to 3 select the four PLL pulse inputs. Codes 4 and 5 select the two external pulse inputs. On the second stage only, code 7 selects the first stage's tick.
- R6: A stage whose source code is unused (code 6 on either stage, code 7 on the first stage) holds its level and tick low and its counter at zero. Code 7 with ratio 256 on the first stage parks it.
- R7: A source or ratio written while a stage runs takes effect only after that stage's next terminal count. The period in progress completes with the old settings.
- R8: The invert bit flips the stage's level while the stage runs, and it takes effect at once. A stopped stage still outputs low.
- R9: The gated bus tick equals the bus tick input only when control bits 1 and 0 are both set. Otherwise it is low.
- R10: The gated peripheral-interface tick equals its input only when control bit 3 is set.
- R11: Control bit 2 enables both stages. While it is clear, both stages hold their level and tick outputs low and keep their counters at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pll_pulse_i | input | 4 | PLL clock enables, source codes 0 to 3 |
| ext_pulse_i | input | 2 | External clock enables, source codes 4 and 5 |
| bus_tick_i | input | 1 | Bus-interface clock enable to be gated |
| pif_tick_i | input | 1 | Peripheral-interface clock enable to be gated |
| bus_tick_o | output | 1 | Gated bus-interface tick |
| pif_tick_o | output | 1 | Gated peripheral-interface tick |
| pre_clk_o | output | 1 | First stage level output |
| gen_clk_o | output | 1 | Second stage level output (generated clock) |
| gen_tick_o | output | 1 | Second stage tick, one per output period |

## Verification
The assertions check several properties on every cycle. A stopped stage's counter returns to zero. A counter never passes the active ratio, and it wraps after each tick. The active source and ratio cannot change in the middle of a period. The gated ticks and the generated tick never appear while their control bits are clear. Reserved words always read zero.

Other behaviours need a run over time, and only the bench scenarios can show them. These are the exact tick counts and high-phase lengths over whole periods, the multiplied ratio through the chained stage, and the 4-then-2 gap sequence after a mid-period ratio change. The bench shows these with a cycle-level reference model under random reconfiguration and random source pulses.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int REG_W   = 32;
  localparam int SEL_W   = 3;
  localparam int DIV_W   = 8;
  localparam int EN_W    = 4;
  // generator word field positions
  localparam int INV_BIT = 1;
  localparam int SRC_LSB = 2;
  localparam int DIV_LSB = 5;
  // control word bit positions
  localparam int EN_BUS_LSB = 0;
  localparam int EN_OUT_BIT = 2;
  localparam int EN_PIF_BIT = 3;
  localparam logic [SEL_W-1:0] SRC_CHAIN = 3'd7;

  typedef struct packed {
    logic [DIV_W-1:0] rm1;
    logic [SEL_W-1:0] src;
    logic             inv;
  } gen_cfg_t;
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = REG_W,
  parameter int N_STAGE = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [EN_W-1:0]           en_o,
  output gen_cfg_t [N_STAGE-1:0]    cfg_o
);
  logic [EN_W-1:0]        en_q;
  gen_cfg_t [N_STAGE-1:0] cfg_q;
  logic                   unused_wbits;

  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else if (we_i) begin
      if (addr_i == '0) en_q <= wdata_i[EN_W-1:0];
      for (int s = 0; s < N_STAGE; s++) begin
        if (addr_i == ADDR_W'(1 + 2 * s)) begin
          cfg_q[s].inv <= wdata_i[INV_BIT];
          cfg_q[s].src <= wdata_i[SRC_LSB +: SEL_W];
          cfg_q[s].rm1 <= wdata_i[DIV_LSB +: DIV_W];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o[EN_W-1:0] = en_q;
    for (int s = 0; s < N_STAGE; s++) begin
      if (addr_i == ADDR_W'(1 + 2 * s)) begin
        rdata_o[INV_BIT]           = cfg_q[s].inv;
        rdata_o[SRC_LSB +: SEL_W]  = cfg_q[s].src;
        rdata_o[DIV_LSB +: DIV_W]  = cfg_q[s].rm1;
      end
    end
  end

  assign en_o  = en_q;
  assign cfg_o = cfg_q;

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(2) || addr_i == ADDR_W'(4)) |-> (rdata_o == '0)); // R2
endmodule

// File: rtl/clkgen_stage.sv
module clkgen_stage
  import clkgen_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter bit CHAIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  gen_cfg_t         cfg_i,
  input  logic [N_SRC-1:0] src_pulse_i,
  input  logic             chain_pulse_i,
  output logic             lvl_o,
  output logic             tick_o
);
  localparam int HI_W = DIV_W + 1;

  logic [SEL_W-1:0] act_src_q;
  logic [DIV_W-1:0] act_rm1_q;
  logic [DIV_W-1:0] cnt_q;
  logic             src_ok, pulse, running, at_end, tc, high_phase;
  logic [HI_W-1:0]  hi_len;

  // source selection over the active (shadow) code
  always_comb begin
    src_ok = 1'b0;
    pulse  = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      if (act_src_q == SEL_W'(k)) begin
        src_ok = 1'b1;
        pulse  = src_pulse_i[k];
      end
    end
    if (CHAIN && act_src_q == SRC_CHAIN) begin
      src_ok = 1'b1;
      pulse  = chain_pulse_i;
    end
  end

  assign running    = enable_i & src_ok;
  assign at_end     = (cnt_q == act_rm1_q);
  assign tc         = running & pulse & at_end;
  assign hi_len     = (HI_W'(act_rm1_q) + HI_W'(2)) >> 1;
  assign high_phase = ({1'b0, cnt_q} < hi_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      act_src_q <= '0;
      act_rm1_q <= '0;
    end else if (!running) begin
      cnt_q     <= '0;
      act_src_q <= cfg_i.src;
      act_rm1_q <= cfg_i.rm1;
    end else if (pulse) begin
      if (at_end) begin
        cnt_q     <= '0;
        act_src_q <= cfg_i.src;
        act_rm1_q <= cfg_i.rm1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o  = running & (high_phase ^ cfg_i.inv);
  assign tick_o = tc;

  AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (cnt_q == '0)); // R6
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_rm1_q); // R3
  AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0)); // R3
  AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tc) |=> (act_src_q == $past(act_src_q) && act_rm1_q == $past(act_rm1_q))); // R7
endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate
  import clkgen_pkg::*;
(
  input  logic [EN_W-1:0] en_i,
  input  logic            bus_tick_i,
  input  logic            pif_tick_i,
  output logic            bus_tick_o,
  output logic            pif_tick_o
);
  logic bus_on, pif_on;
  assign bus_on     = &en_i[EN_BUS_LSB +: 2];
  assign pif_on     = en_i[EN_PIF_BIT];
  assign bus_tick_o = bus_tick_i & bus_on;
  assign pif_tick_o = pif_tick_i & pif_on;
endmodule

// File: rtl/twostage_clkgen.sv
module twostage_clkgen
  import clkgen_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = REG_W,
  parameter int N_PLL   = 4,
  parameter int N_EXT   = 2,
  parameter int N_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_PLL-1:0]  pll_pulse_i,
  input  logic [N_EXT-1:0]  ext_pulse_i,
  input  logic              bus_tick_i,
  input  logic              pif_tick_i,
  output logic              bus_tick_o,
  output logic              pif_tick_o,
  output logic              pre_clk_o,
  output logic              gen_clk_o,
  output logic              gen_tick_o
);
  localparam int N_SRC = N_PLL + N_EXT;

  logic [EN_W-1:0]        en_w;
  gen_cfg_t [N_STAGE-1:0] cfg_w;
  logic [N_SRC-1:0]       src_w;
  logic [N_STAGE-1:0]     tick_w, lvl_w;

  assign src_w = {ext_pulse_i, pll_pulse_i};

  clkgen_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_STAGE(N_STAGE)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .en_o(en_w), .cfg_o(cfg_w)
  );

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    logic chain_in;
    if (s == 0) begin : g_head
      assign chain_in = 1'b0;
    end else begin : g_link
      assign chain_in = tick_w[s-1];
    end
    clkgen_stage #(.N_SRC(N_SRC), .CHAIN(s > 0)) u_stage (
      .clk(clk), .rst_n(rst_n), .enable_i(en_w[EN_OUT_BIT]), .cfg_i(cfg_w[s]),
      .src_pulse_i(src_w), .chain_pulse_i(chain_in),
      .lvl_o(lvl_w[s]), .tick_o(tick_w[s])
    );
  end

  clkgen_gate u_gate (
    .en_i(en_w), .bus_tick_i(bus_tick_i), .pif_tick_i(pif_tick_i),
    .bus_tick_o(bus_tick_o), .pif_tick_o(pif_tick_o)
  );

  assign pre_clk_o  = lvl_w[0];
  assign gen_clk_o  = lvl_w[N_STAGE-1];
  assign gen_tick_o = tick_w[N_STAGE-1];

  AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_tick_o || gen_clk_o || pre_clk_o) |-> en_w[EN_OUT_BIT]); // R11
  AST_BUS_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tick_o |-> (en_w[1:0] == 2'b11)); // R9
  AST_PIF_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pif_tick_o |-> en_w[EN_PIF_BIT]); // R10
endmodule

// File: tb/twostage_clkgen_tb.sv
module twostage_clkgen_tb;
  localparam time CLK_PER = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pll_pulse_i = '0;
  logic [1:0]  ext_pulse_i = '0;
  logic        bus_tick_i = 1'b0, pif_tick_i = 1'b0;
  logic        bus_tick_o, pif_tick_o, pre_clk_o, gen_clk_o, gen_tick_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // next-cycle stimulus, copied onto the pins at the falling edge
  bit [3:0] nx_pll = '0;
  bit [1:0] nx_ext = '0;
  bit       nx_bus = 1'b0, nx_pif = 1'b0;

  // reference model state
  bit [3:0] m_en = '0;
  bit       m_inv [2];
  int       m_src [2];
  int       m_rm1 [2];
  int       m_asrc[2];
  int       m_arm1[2];
  int       m_cnt [2];

  // last observed outputs
  bit       o_tick, o_gen, o_pre, o_bus, o_pif;
  bit [31:0] o_rd;

  always #(CLK_PER/2) clk = ~clk;

  twostage_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_pulse_i(pll_pulse_i),
    .ext_pulse_i(ext_pulse_i), .bus_tick_i(bus_tick_i), .pif_tick_i(pif_tick_i),
    .bus_tick_o(bus_tick_o), .pif_tick_o(pif_tick_o), .pre_clk_o(pre_clk_o),
    .gen_clk_o(gen_clk_o), .gen_tick_o(gen_tick_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] mkw(input bit inv, input int src, input int rm1);
    return (32'(rm1 & 255) << 5) | (32'(src & 7) << 2) | (32'(inv) << 1);
  endfunction

  function automatic bit src_ok(input int s, input int code);
    return (code < 6) || (s == 1 && code == 7);
  endfunction

  function automatic bit src_sel(input int code, input bit chain);
    if (code < 4) return pll_pulse_i[code];
    if (code < 6) return ext_pulse_i[code-4];
    if (code == 7) return chain;
    return 1'b0;
  endfunction

  function automatic bit [31:0] gword(input int s);
    return mkw(m_inv[s], m_src[s], m_rm1[s]);
  endfunction

  // one reference cycle: drive, compare against model, advance model
  task automatic step(input bit we, input int addr, input bit [31:0] wd);
    bit pls[2], run[2], tc[2], lv[2];
    bit [31:0] exp_rd;
    bit e_bus, e_pif;
    @(negedge clk);
    reg_we = we; reg_addr = 3'(addr); reg_wdata = wd;
    pll_pulse_i = nx_pll; ext_pulse_i = nx_ext;
    bus_tick_i = nx_bus; pif_tick_i = nx_pif;
    #1;
    for (int s = 0; s < 2; s++) begin
      pls[s] = src_sel(m_asrc[s], (s == 0) ? 1'b0 : tc[0]);
      run[s] = m_en[2] && src_ok(s, m_asrc[s]);
      tc[s]  = run[s] && pls[s] && (m_cnt[s] == m_arm1[s]);
      lv[s]  = run[s] && ((m_cnt[s] < (m_arm1[s] + 2) / 2) ^ m_inv[s]);
    end
    e_bus = bus_tick_i && (m_en[1:0] == 2'b11);
    e_pif = pif_tick_i && m_en[3];
    case (addr)
      0: exp_rd = {28'b0, m_en};
      1: exp_rd = gword(0);
      3: exp_rd = gword(1);
      default: exp_rd = '0;
    endcase
    o_tick = gen_tick_o; o_gen = gen_clk_o; o_pre = pre_clk_o;
    o_bus = bus_tick_o; o_pif = pif_tick_o; o_rd = reg_rdata;
    chk(o_tick == tc[1], "R3 tick per period", o_tick, tc[1]);
    chk(o_gen == lv[1], "R4 stage2 level", o_gen, lv[1]);
    chk(o_pre == lv[0], "R8 stage1 level", o_pre, lv[0]);
    chk(o_bus == e_bus, "R9 bus gate", o_bus, e_bus);
    chk(o_pif == e_pif, "R10 pif gate", o_pif, e_pif);
    chk(o_rd == exp_rd, "R2 readback", o_rd, exp_rd);
    for (int s = 0; s < 2; s++) begin
      if (!run[s]) begin
        m_cnt[s] = 0; m_asrc[s] = m_src[s]; m_arm1[s] = m_rm1[s];
      end else if (pls[s]) begin
        if (m_cnt[s] == m_arm1[s]) begin
          m_cnt[s] = 0; m_asrc[s] = m_src[s]; m_arm1[s] = m_rm1[s];
        end else m_cnt[s]++;
      end
    end
    if (we) begin
      if (addr == 0) m_en = wd[3:0];
      if (addr == 1 || addr == 3) begin
        m_inv[addr/2] = wd[1]; m_src[addr/2] = int'(wd[4:2]); m_rm1[addr/2] = int'(wd[12:5]);
      end
    end
  endtask

  task automatic wr(input int addr, input bit [31:0] wd);
    step(1'b1, addr, wd);
  endtask

  task automatic rd(input int addr);
    step(1'b0, addr, 32'd0);
  endtask

  task automatic run_cnt(input int n, output int ticks, output int ghi, output int phi);
    ticks = 0; ghi = 0; phi = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b0, 0, 32'd0);
      ticks += int'(o_tick); ghi += int'(o_gen); phi += int'(o_pre);
    end
  endtask

  task automatic cfg_run(input bit [31:0] g0, input bit [31:0] g2, input bit [3:0] en);
    int t, g, p;
    wr(0, 32'd0); wr(1, g0); wr(3, g2); wr(0, {28'b0, en});
    run_cnt(4, t, g, p);
  endtask

  localparam bit [31:0] PARK = 32'((255 << 5) | (7 << 2));

  initial begin
    int t, g, p, gap1, gap2;
    for (int s = 0; s < 2; s++) begin
      m_inv[s] = 0; m_src[s] = 0; m_rm1[s] = 0; m_asrc[s] = 0; m_arm1[s] = 0; m_cnt[s] = 0;
    end
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    nx_pll = 4'hF; nx_ext = 2'b11; nx_bus = 1; nx_pif = 1;
    for (int a = 0; a < 5; a++) begin
      rd(a);
      chk(o_rd == 0, "R1 register after reset", o_rd, 0);
    end
    chk(!o_tick && !o_gen && !o_pre && !o_bus && !o_pif, "R1 outputs after reset",
        {o_tick, o_gen, o_pre, o_bus, o_pif}, 0);

    // R2: field layout and reserved words
    wr(1, 32'hFFFF_FFFF); rd(1);
    chk(o_rd == 32'h1FFE, "R2 generator word bits", o_rd, 32'h1FFE);
    wr(2, 32'hFFFF_FFFF); rd(2);
    chk(o_rd == 0, "R2 reserved word 2", o_rd, 0);
    wr(4, 32'hFFFF_FFFF); rd(4);
    chk(o_rd == 0, "R2 reserved word 4", o_rd, 0);
    rd(5);
    chk(o_rd == 0, "R2 unmapped word", o_rd, 0);
    wr(0, 32'hFFFF_FFFF); rd(0);
    chk(o_rd == 32'hF, "R2 control word bits", o_rd, 32'hF);
    nx_bus = 0; nx_pif = 0; nx_ext = 0;

    // R3 R4: stage two alone, ratio 5 from PLL 1, stage one parked (R6)
    nx_pll = 4'b0010;
    cfg_run(PARK, mkw(0, 1, 4), 4'b0100);
    run_cnt(50, t, g, p);
    chk(t == 10, "R3 ratio 5 tick count", t, 10);
    chk(g == 30, "R4 ratio 5 high cycles", g, 30);
    chk(p == 0, "R6 parked stage one stays low", p, 0);

    // R5: chained ratio 4 then 2
    nx_pll = 4'b0001;
    cfg_run(mkw(0, 0, 3), mkw(0, 7, 1), 4'b0100);
    run_cnt(48, t, g, p);
    chk(t == 6, "R5 chained tick count", t, 6);
    chk(p == 24, "R4 ratio 4 stage one high cycles", p, 24);

    // R5: external inputs
    nx_pll = 0; nx_ext = 2'b01;
    cfg_run(PARK, mkw(0, 4, 2), 4'b0100);
    run_cnt(30, t, g, p);
    chk(t == 10, "R5 external 0 tick count", t, 10);
    cfg_run(PARK, mkw(0, 5, 2), 4'b0100);
    run_cnt(30, t, g, p);
    chk(t == 0, "R5 external 1 idle input", t, 0);

    // R8: inversion on both stages, ratio 5
    nx_ext = 0; nx_pll = 4'b0001;
    cfg_run(mkw(1, 0, 4), mkw(1, 0, 4), 4'b0100);
    run_cnt(50, t, g, p);
    chk(g == 20, "R8 inverted stage two high cycles", g, 20);
    chk(p == 20, "R8 inverted stage one high cycles", p, 20);

    // R6: unused code 6
    cfg_run(PARK, mkw(0, 6, 0), 4'b0100);
    run_cnt(30, t, g, p);
    chk(t == 0 && g == 0, "R6 code 6 idle", t + g, 0);

    // R11: output enable clear
    cfg_run(mkw(0, 0, 1), mkw(0, 0, 1), 4'b0000);
    run_cnt(30, t, g, p);
    chk(t == 0 && g == 0 && p == 0, "R11 disabled output", t + g + p, 0);

    // R7: ratio change mid-period
    cfg_run(PARK, mkw(0, 0, 3), 4'b0100);
    do step(1'b0, 0, 32'd0); while (!o_tick);
    wr(3, mkw(0, 0, 1));
    gap1 = 1;
    while (!o_tick) begin step(1'b0, 0, 32'd0); gap1++; end
    gap2 = 0;
    do begin step(1'b0, 0, 32'd0); gap2++; end while (!o_tick);
    chk(gap1 == 4, "R7 old ratio completes", gap1, 4);
    chk(gap2 == 2, "R7 new ratio after terminal count", gap2, 2);

    // R9 R10: interface gating
    nx_bus = 1; nx_pif = 1;
    wr(0, 32'h1); rd(0);
    chk(!o_bus && !o_pif, "R9 one bus bit is not enough", o_bus, 0);
    wr(0, 32'h3); rd(0);
    chk(o_bus && !o_pif, "R9 both bus bits pass", o_bus, 1);
    wr(0, 32'h8); rd(0);
    chk(!o_bus && o_pif, "R10 pif bit passes", o_pif, 1);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      nx_pll = 4'($urandom); nx_ext = 2'($urandom);
      nx_bus = 1'($urandom); nx_pif = 1'($urandom);
      if ($urandom % 12 == 0) begin
        int a;
        bit [31:0] d;
        a = int'($urandom % 6);
        d = $urandom;
        if (a == 1 || a == 3) d = mkw(1'($urandom), int'($urandom % 8), int'($urandom % 10));
        if (a == 0 && ($urandom % 4 != 0)) d[2] = 1'b1;
        step(1'b1, a, d);
      end else begin
        step(1'b0, int'($urandom % 6), 32'd0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule